// File: doc/BRIEF.md
# ISA I/O Window Address Translator

This block sits between a big-endian CPU's physical bus and a 16-bit ISA I/O port space. A CPU access that lands in the 8 MB I/O window at 0x80000000 is turned into an ISA port request. The port address is folded from the window offset using one of two maps, picked by the `map_sparse` input. Multi-byte data is byte-swapped in both directions, so the CPU sees the little-endian peripherals in its own byte order.

A 4-byte interrupt-acknowledge aperture at 0xBFFFFFF0 is also decoded. A read of its first byte raises a one-cycle request to an external interrupt controller and waits for its vector. Every other access either fails to decode or is a write to the aperture, and completes at once without any downstream request. Only one transaction is in flight at a time.

The controller has five states:
- `ST_IDLE` accepts a request.
- `ST_ISA` holds the ISA request until `isa_done`.
- `ST_ACK_REQ` drives the one-cycle acknowledge request.
- `ST_ACK_WAIT` waits for `ack_valid`.
- `ST_RESP` presents the result for one cycle.

The transitions are:
- IDLE→ISA for a window access.
- IDLE→ACK_REQ for a read at exactly 0xBFFFFFF0.
- IDLE→RESP for everything else.
- ISA→RESP on `isa_done`.
- ACK_REQ→RESP when `ack_valid` is already high, otherwise ACK_REQ→ACK_WAIT.
- ACK_WAIT→RESP on `ack_valid`.
- RESP→IDLE always.

Top module: `isa_io_bridge`

## Requirements
- R1: A request accepted in idle (cpu_req high while cpu_busy low) whose address lies in 0x80000000..0x807FFFFF raises isa_req from the next cycle. isa_req stays high with isa_addr, isa_size, isa_we and isa_wdata stable until the cycle in which isa_done is high.
- R2: With map_sparse = 0, isa_addr equals the window offset bits [15:0].
- R3: With map_sparse = 1, isa_addr bits [15:5] equal offset bits [22:12] and isa_addr bits [4:0] equal offset bits [4:0].
- R4: cpu_size encodes 0 = byte, 1 = halfword, 2 = word. Byte accesses pass write and read data through unchanged.
- R5: A halfword access swaps bits [7:0] with [15:8] in both directions, and the upper 16 bits are zero.
- R6: A word access reverses all four bytes in both directions.
- R7: A write anywhere in 0xBFFFFFF0..0xBFFFFFF3 raises neither isa_req nor ack_req, and completes in the following cycle.
- R8: A read at 0xBFFFFFF0 raises ack_req for exactly one cycle and waits for ack_valid. It then returns ack_vector zero-extended and byte-swapped per R4 to R6.
- R9: A read at 0xBFFFFFF1..0xBFFFFFF3 returns 0 in the following cycle without raising ack_req.
- R10: An access outside both the window and the aperture is not forwarded. It completes in the following cycle with cpu_rdata = 0xFFFFFFFF.
- R11: cpu_done is high for exactly one cycle per transaction, and cpu_busy is high from acceptance through the cpu_done cycle. A request presented while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| map_sparse | input | 1 | 0 = flat 64 KB map, 1 = sparse page-folded map |
| cpu_req | input | 1 | CPU request strobe, sampled in idle |
| cpu_addr | input | 32 | CPU physical address |
| cpu_size | input | 2 | 0 byte, 1 halfword, 2 word |
| cpu_we | input | 1 | 1 = write |
| cpu_wdata | input | 32 | CPU write data, CPU byte order |
| cpu_busy | output | 1 | Transaction in progress |
| cpu_done | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | 32 | Read result, valid with cpu_done |
| isa_req | output | 1 | ISA request, held until isa_done |
| isa_addr | output | 16 | ISA port address |
| isa_size | output | 2 | ISA access size |
| isa_we | output | 1 | ISA write |
| isa_wdata | output | 32 | ISA write data, little-endian order |
| isa_done | input | 1 | ISA completion |
| isa_rdata | input | 32 | ISA read data, little-endian order |
| ack_req | output | 1 | One-cycle interrupt acknowledge request |
| ack_valid | input | 1 | Acknowledge vector valid |
| ack_vector | input | 8 | Interrupt vector |

## Verification
The bench drives inputs on the falling edge and samples half a cycle after each rising edge. The ISA request and its folded address and swapped write data are due in the cycle after acceptance. A local reply (out of range, aperture write, aperture read off the first byte) shows cpu_done and its data in that same cycle. For forwarded accesses, cpu_done and the swapped read data follow one cycle after isa_done or ack_valid is seen, and the bench checks in exactly those cycles. The one-cycle acknowledge request is checked both in the cycle after acceptance and one cycle later, to confirm it has fallen.

// File: rtl/isa_io_pkg.sv
package isa_io_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2
    } size_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ISA,
        ST_ACK_REQ,
        ST_ACK_WAIT,
        ST_RESP
    } state_t;

endpackage

// File: rtl/isa_addr_fold.sv
module isa_addr_fold #(
    parameter int WIN_BITS   = 23,
    parameter int PORT_W     = 16,
    parameter int PAGE_LSB   = 12,
    parameter int PAGE_SHIFT = 7,
    parameter int LOW_BITS   = 5
) (
    input  logic [WIN_BITS-1:0] offset,
    input  logic                sparse,
    output logic [PORT_W-1:0]   port
);
    localparam logic [WIN_BITS-1:0] PAGE_MASK = ~((WIN_BITS'(1) << PAGE_LSB) - WIN_BITS'(1));

    logic [WIN_BITS-1:0] page_bits;
    logic [WIN_BITS-1:0] page_down;
    logic [PORT_W-1:0]   low_part;

    always_comb begin
        page_bits = offset & PAGE_MASK;
        page_down = page_bits >> PAGE_SHIFT;
        low_part  = {{(PORT_W-LOW_BITS){1'b0}}, offset[LOW_BITS-1:0]};
        port      = sparse ? (page_down[PORT_W-1:0] | low_part) : offset[PORT_W-1:0];
    end
endmodule

// File: rtl/isa_lane_swap.sv
module isa_lane_swap
    import isa_io_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [1:0]        size,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout
);
    localparam int LANES = DATA_W / 8;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        always_comb begin
            unique case (size_t'(size))
                SZ_HALF: dout[i*8 +: 8] = (i < 2) ? din[(1-i)*8 +: 8] : 8'h00;
                SZ_WORD: dout[i*8 +: 8] = din[(LANES-1-i)*8 +: 8];
                default: dout[i*8 +: 8] = din[i*8 +: 8];
            endcase
        end
    end
endmodule

// File: rtl/isa_io_bridge.sv
module isa_io_bridge
    import isa_io_pkg::*;
#(
    parameter int           ADDR_W   = 32,
    parameter int           DATA_W   = 32,
    parameter int           PORT_W   = 16,
    parameter int           VEC_W    = 8,
    parameter int           WIN_BITS = 23,
    parameter logic [31:0]  WIN_BASE = 32'h8000_0000,
    parameter logic [31:0]  ACK_BASE = 32'hBFFF_FFF0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              map_sparse,
    input  logic              cpu_req,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [1:0]        cpu_size,
    input  logic              cpu_we,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic              cpu_busy,
    output logic              cpu_done,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              isa_req,
    output logic [PORT_W-1:0] isa_addr,
    output logic [1:0]        isa_size,
    output logic              isa_we,
    output logic [DATA_W-1:0] isa_wdata,
    input  logic              isa_done,
    input  logic [DATA_W-1:0] isa_rdata,
    output logic              ack_req,
    input  logic              ack_valid,
    input  logic [VEC_W-1:0]  ack_vector
);
    localparam int ACK_BITS = 2;

    state_t state_q, state_d;

    logic              in_win, in_ack, ack_first, accept;
    logic [PORT_W-1:0] port_d;
    logic [DATA_W-1:0] wdata_sw, rd_src, rd_sw;
    logic [PORT_W-1:0] port_q;
    logic [1:0]        size_q;
    logic              we_q;
    logic [DATA_W-1:0] wdata_q, rdata_q;

    // address decode
    always_comb begin
        in_win    = (cpu_addr[ADDR_W-1:WIN_BITS] == WIN_BASE[ADDR_W-1:WIN_BITS]);
        in_ack    = (cpu_addr[ADDR_W-1:ACK_BITS] == ACK_BASE[ADDR_W-1:ACK_BITS]);
        ack_first = in_ack && (cpu_addr[3:0] == 4'h0);
        accept    = cpu_req && (state_q == ST_IDLE);
    end

    isa_addr_fold #(
        .WIN_BITS(WIN_BITS),
        .PORT_W  (PORT_W)
    ) u_fold (
        .offset(cpu_addr[WIN_BITS-1:0]),
        .sparse(map_sparse),
        .port  (port_d)
    );

    isa_lane_swap #(.DATA_W(DATA_W)) u_wswap (
        .size(cpu_size),
        .din (cpu_wdata),
        .dout(wdata_sw)
    );

    assign rd_src = (state_q == ST_ISA) ? isa_rdata
                                        : {{(DATA_W-VEC_W){1'b0}}, ack_vector};

    isa_lane_swap #(.DATA_W(DATA_W)) u_rswap (
        .size(size_q),
        .din (rd_src),
        .dout(rd_sw)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (accept) begin
                    if (in_win)                 state_d = ST_ISA;
                    else if (ack_first && !cpu_we) state_d = ST_ACK_REQ;
                    else                        state_d = ST_RESP;
                end
            end
            ST_ISA:      if (isa_done)  state_d = ST_RESP;
            ST_ACK_REQ:  state_d = ack_valid ? ST_RESP : ST_ACK_WAIT;
            ST_ACK_WAIT: if (ack_valid) state_d = ST_RESP;
            ST_RESP:     state_d = ST_IDLE;
            default:     state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        cpu_busy = (state_q != ST_IDLE);
        cpu_done = (state_q == ST_RESP);
        isa_req  = (state_q == ST_ISA);
        ack_req  = (state_q == ST_ACK_REQ);
    end

    // captured request and result
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            port_q  <= '0;
            size_q  <= '0;
            we_q    <= 1'b0;
            wdata_q <= '0;
            rdata_q <= '0;
        end else begin
            if (accept) begin
                port_q  <= port_d;
                size_q  <= cpu_size;
                we_q    <= cpu_we;
                wdata_q <= wdata_sw;
                rdata_q <= (in_win || in_ack) ? '0 : '1;
            end
            if (state_q == ST_ISA && isa_done && !we_q)
                rdata_q <= rd_sw;
            if ((state_q == ST_ACK_REQ || state_q == ST_ACK_WAIT) && ack_valid)
                rdata_q <= rd_sw;
        end
    end

    assign isa_addr  = port_q;
    assign isa_size  = size_q;
    assign isa_we    = we_q;
    assign isa_wdata = wdata_q;
    assign cpu_rdata = rdata_q;

endmodule

// File: rtl/isa_io_bridge_chk.sv
module isa_io_bridge_chk #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int PORT_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cpu_req,
    input logic [ADDR_W-1:0] cpu_addr,
    input logic              cpu_we,
    input logic              cpu_busy,
    input logic              cpu_done,
    input logic [DATA_W-1:0] cpu_rdata,
    input logic              isa_req,
    input logic [PORT_W-1:0] isa_addr,
    input logic [DATA_W-1:0] isa_wdata,
    input logic              isa_done,
    input logic              ack_req
);
    logic c_win, c_ap, c_new;
    assign c_win = (cpu_addr >= 32'h8000_0000) && (cpu_addr <= 32'h807F_FFFF);
    assign c_ap  = (cpu_addr >= 32'hBFFF_FFF0) && (cpu_addr <= 32'hBFFF_FFF3);
    assign c_new = cpu_req && !cpu_busy;

    assert_hold_req_R1: assert property (@(posedge clk) disable iff (!rst_n)
        isa_req && !isa_done |=> isa_req);
    assert_stable_port_R1: assert property (@(posedge clk) disable iff (!rst_n)
        isa_req && !isa_done |=> $stable(isa_addr) && $stable(isa_wdata));
    assert_win_forward_R1: assert property (@(posedge clk) disable iff (!rst_n)
        c_new && c_win |=> isa_req && !ack_req);
    assert_ap_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        c_new && c_ap && cpu_we |=> cpu_done && !isa_req && !ack_req);
    assert_ack_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ack_req |=> !ack_req);
    assert_ap_offbyte_R9: assert property (@(posedge clk) disable iff (!rst_n)
        c_new && c_ap && !cpu_we && (cpu_addr[1:0] != 2'b00) |=> cpu_done && !ack_req && (cpu_rdata == '0));
    assert_outside_R10: assert property (@(posedge clk) disable iff (!rst_n)
        c_new && !c_win && !c_ap |=> cpu_done && !isa_req && (cpu_rdata == '1));
    assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_done |=> !cpu_done && !cpu_busy);
    assert_isa_finish_R11: assert property (@(posedge clk) disable iff (!rst_n)
        isa_req && isa_done |=> cpu_done);
    assert_done_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_done |-> cpu_busy);
endmodule

bind isa_io_bridge isa_io_bridge_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PORT_W(PORT_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cpu_req  (cpu_req),
    .cpu_addr (cpu_addr),
    .cpu_we   (cpu_we),
    .cpu_busy (cpu_busy),
    .cpu_done (cpu_done),
    .cpu_rdata(cpu_rdata),
    .isa_req  (isa_req),
    .isa_addr (isa_addr),
    .isa_wdata(isa_wdata),
    .isa_done (isa_done),
    .ack_req  (ack_req)
);

// File: tb/isa_io_bridge_test.sv
module isa_io_bridge_test;
    logic        clk = 0;
    logic        rst_n = 0;
    logic        map_sparse = 0;
    logic        cpu_req = 0;
    logic [31:0] cpu_addr = '0;
    logic [1:0]  cpu_size = '0;
    logic        cpu_we = 0;
    logic [31:0] cpu_wdata = '0;
    logic        cpu_busy, cpu_done;
    logic [31:0] cpu_rdata;
    logic        isa_req;
    logic [15:0] isa_addr;
    logic [1:0]  isa_size;
    logic        isa_we;
    logic [31:0] isa_wdata;
    logic        isa_done = 0;
    logic [31:0] isa_rdata = '0;
    logic        ack_req;
    logic        ack_valid = 0;
    logic [7:0]  ack_vector = '0;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #5 clk = ~clk;

    isa_io_bridge uut (
        .clk(clk), .rst_n(rst_n), .map_sparse(map_sparse),
        .cpu_req(cpu_req), .cpu_addr(cpu_addr), .cpu_size(cpu_size),
        .cpu_we(cpu_we), .cpu_wdata(cpu_wdata),
        .cpu_busy(cpu_busy), .cpu_done(cpu_done), .cpu_rdata(cpu_rdata),
        .isa_req(isa_req), .isa_addr(isa_addr), .isa_size(isa_size),
        .isa_we(isa_we), .isa_wdata(isa_wdata),
        .isa_done(isa_done), .isa_rdata(isa_rdata),
        .ack_req(ack_req), .ack_valid(ack_valid), .ack_vector(ack_vector)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic issue(input logic [31:0] a, input logic [1:0] sz, input logic we,
                         input logic [31:0] wd);
        cpu_req = 1; cpu_addr = a; cpu_size = sz; cpu_we = we; cpu_wdata = wd;
        @(negedge clk);
        cpu_req = 0;
    endtask

    // forwarded window access, full handshake
    task automatic t_io(input string tag, input logic sp, input logic [31:0] a,
                        input logic [1:0] sz, input logic we, input logic [31:0] wd,
                        input logic [15:0] exp_port, input logic [31:0] exp_wd,
                        input logic [31:0] rd, input logic [31:0] exp_rd);
        map_sparse = sp;
        issue(a, sz, we, wd);
        check({tag, " isa_req R1"}, {31'b0, isa_req}, 32'd1);
        check({tag, " port"}, {16'b0, isa_addr}, {16'b0, exp_port});
        if (we) check({tag, " wdata"}, isa_wdata, exp_wd);
        @(negedge clk);
        check({tag, " held R1"}, {31'b0, isa_req}, 32'd1);
        isa_done = 1; isa_rdata = rd;
        @(negedge clk);
        isa_done = 0;
        check({tag, " done R11"}, {30'b0, cpu_done, cpu_busy}, 32'd3);
        if (!we) check({tag, " rdata"}, cpu_rdata, exp_rd);
        @(negedge clk);
        check({tag, " idle R11"}, {30'b0, cpu_done, cpu_busy}, 32'd0);
    endtask

    task automatic t_local(input string tag, input logic [31:0] a, input logic we,
                           input logic [31:0] exp_rd);
        issue(a, 2'd2, we, 32'h1234_5678);
        check({tag, " done"}, {29'b0, cpu_done, isa_req, ack_req}, 32'd4);
        if (!we) check({tag, " rdata"}, cpu_rdata, exp_rd);
        @(negedge clk);
        check({tag, " idle"}, {31'b0, cpu_busy}, 32'd0);
    endtask

    task automatic t_ack(input string tag, input logic [1:0] sz, input logic [7:0] v,
                         input logic [31:0] exp_rd);
        issue(32'hBFFF_FFF0, sz, 1'b0, '0);
        check({tag, " ack_req R8"}, {30'b0, ack_req, isa_req}, 32'd2);
        @(negedge clk);
        check({tag, " ack pulse R8"}, {30'b0, ack_req, cpu_done}, 32'd0);
        ack_valid = 1; ack_vector = v;
        @(negedge clk);
        ack_valid = 0;
        check({tag, " done R8"}, {31'b0, cpu_done}, 32'd1);
        check({tag, " vector"}, cpu_rdata, exp_rd);
        @(negedge clk);
    endtask

    task automatic t_busy_ignore();
        map_sparse = 0;
        issue(32'h8000_0060, 2'd0, 1'b0, '0);
        cpu_req = 1; cpu_addr = 32'h0000_0000;
        @(negedge clk);
        cpu_req = 0;
        check("R11 busy request ignored, port kept", {16'b0, isa_addr}, 32'h0060);
        isa_done = 1; isa_rdata = 32'h0000_0042;
        @(negedge clk);
        isa_done = 0;
        check("R11 rdata from first", cpu_rdata, 32'h42);
        @(negedge clk);
        check("R11 no second txn", {30'b0, cpu_busy, cpu_done}, 32'd0);
    endtask

    initial begin
        while (cycles < 20000) begin
            @(posedge clk);
            cycles++;
        end
        errors++;
        $display("FAIL watchdog R11 actual=hang expected=finish");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("reset R11", {28'b0, cpu_busy, cpu_done, isa_req, ack_req}, 32'd0);
        rst_n = 1;
        @(negedge clk);
        // R2 contiguous, R4 byte write
        t_io("R2 R4 byte wr", 0, 32'h8000_1234, 2'd0, 1, 32'h0000_00A5, 16'h1234, 32'h0000_00A5, '0, '0);
        t_io("R2 high bits dropped", 0, 32'h8001_0398, 2'd0, 0, '0, 16'h0398, '0, 32'h0000_005A, 32'h0000_005A);
        // R3 sparse
        t_io("R3 sparse a", 1, 32'h8007_F01F, 2'd0, 0, '0, 16'h0FFF, '0, 32'h11, 32'h11);
        t_io("R3 sparse b", 1, 32'h807F_F003, 2'd0, 0, '0, 16'hFFE3, '0, 32'h22, 32'h22);
        t_io("R3 sparse c", 1, 32'h8000_0C98, 2'd0, 0, '0, 16'h0018, '0, 32'h33, 32'h33);
        // R5 halfword
        t_io("R5 half wr", 0, 32'h8000_01F0, 2'd1, 1, 32'h0000_1234, 16'h01F0, 32'h0000_3412, '0, '0);
        t_io("R5 half rd", 0, 32'h8000_01F0, 2'd1, 0, '0, 16'h01F0, '0, 32'h0000_BEEF, 32'h0000_EFBE);
        // R6 word
        t_io("R6 word wr", 0, 32'h8000_0CF8, 2'd2, 1, 32'h1122_3344, 16'h0CF8, 32'h4433_2211, '0, '0);
        t_io("R6 word rd", 0, 32'h8000_0CFC, 2'd2, 0, '0, 16'h0CFC, '0, 32'hDEAD_BEEF, 32'hEFBE_ADDE);
        // R7 aperture writes
        t_local("R7 ap write f0", 32'hBFFF_FFF0, 1, '0);
        t_local("R7 ap write f3", 32'hBFFF_FFF3, 1, '0);
        // R9
        t_local("R9 ap read f1", 32'hBFFF_FFF1, 0, 32'h0);
        t_local("R9 ap read f2", 32'hBFFF_FFF2, 0, 32'h0);
        // R10
        t_local("R10 outside low", 32'h7FFF_FFFF, 0, 32'hFFFF_FFFF);
        t_local("R10 past window", 32'h8080_0000, 0, 32'hFFFF_FFFF);
        t_local("R10 past aperture", 32'hBFFF_FFF4, 0, 32'hFFFF_FFFF);
        // R8
        t_ack("R8 R4 byte", 2'd0, 8'h2C, 32'h0000_002C);
        t_ack("R8 R5 half", 2'd1, 8'h2C, 32'h0000_2C00);
        t_ack("R8 R6 word", 2'd2, 8'h2C, 32'h2C00_0000);
        t_busy_ignore();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule